// File: doc/BRIEF.md
# Nine-Bit Serial Frame Transmitter

This block turns a host byte plus one extra (ninth) bit into an eleven-bit asynchronous serial frame: a low start bit, the eight data bits least significant first, the ninth bit, and a high stop level. It takes no part in making the bit rate. A free-running divide-by-16 counter elsewhere supplies a one-cycle pulse at each rollover, and every bit boundary falls on one of these pulses. Because of this, a frame begins at the first rollover after the host write, not at the write.

The host presents a byte and the ninth-bit value together with a one-cycle write strobe. A sticky completion flag rises when the frame has left, and stays up until the host pulses a clear strobe. Internally, the end of the frame is found without a bit counter. The shift register fills with zeros from the top, behind a single marker one that the first shift inserts. When the marker lands directly above the output position, the controller knows the ninth bit is on the line and makes its last shift.

Top module: `ninebit_frame_tx`

## Requirements
- R1: While reset is asserted and after it is released, `txd` is 1 and `tx_done` is 0.
- R2: A write strobe taken while the block is idle loads `wr_data` and `wr_bit9`. The frame then carries exactly those values.
- R3: The start bit (`txd` = 0) appears in the cycle after the first `bit_tick` that follows the accepted write. A `bit_tick` in the same cycle as the write does not count.
- R4: Each frame bit occupies exactly one bit time, from one `bit_tick` to the next. The order is start, `wr_data[0]` through `wr_data[7]`, then `wr_bit9`.
- R5: `tx_done` rises in the cycle after the 11th `bit_tick` counted from the write. From that point `txd` stays 1, which forms the stop level.
- R6: A write strobe that arrives while a frame is waiting for its first tick or is in progress is ignored. The frame in flight is unchanged.
- R7: `tx_done` stays at 1 until `tx_clr` is pulsed. If the setting event and `tx_clr` fall in the same cycle, the flag is set.
- R8: `txd` is 1 whenever no start or data bit is being sent, including the wait for the first tick.
- R9: A new write is accepted as soon as the previous frame has ended, whatever the state of `tx_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse at each divide-by-16 rollover |
| wr_stb | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to send |
| wr_bit9 | input | 1 | Ninth bit to send |
| tx_clr | input | 1 | Clears the completion flag |
| txd | output | 1 | Serial output line |
| tx_done | output | 1 | Sticky transmit-complete flag |

## Verification
The hardest cases to reach are the ones where a strobe lands on a precise cycle relative to a rollover. These are a write in the very cycle of a tick, extra writes during the wait and start phases, and a clear that coincides with the final tick. The stimulus watches the bench's own rollover counter one cycle ahead and drives the strobe so it lands on the chosen edge. For the coincident clear, `tx_clr` is held high across the end of a frame. The data patterns include an all-zero byte with a zero ninth bit, and a byte whose bit 1 alone is set. Both are the cases where a marker-based end detector that ignored the first shift would stop early.

// File: rtl/ninebit_tx_pkg.sv
package ninebit_tx_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_WAIT  = 2'd1,
      PH_START = 2'd2,
      PH_DATA  = 2'd3
   } tx_phase_t;
endpackage

// File: rtl/ntx_shifter.sv
module ntx_shifter #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   output logic         lsb,
   output logic         at_last,
   output logic [W-1:0] frame
);
   localparam int UW = W - 1;

   logic [W-1:0] sreg;
   logic         marked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg   <= '1;
         marked <= 1'b0;
      end else if (load) begin
         sreg   <= load_val;
         marked <= 1'b0;
      end else if (shift) begin
         // first shift brings in the marker one, later shifts bring zeros
         sreg   <= {~marked, sreg[W-1:1]};
         marked <= 1'b1;
      end
   end

   assign lsb     = sreg[0];
   assign at_last = marked && (sreg[W-1:1] == UW'(1));
   assign frame   = sreg;
endmodule

// File: rtl/ntx_sequencer.sv
module ntx_sequencer
   import ninebit_tx_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      wr_req,
   input  logic      at_last,
   output tx_phase_t phase,
   output logic      load,
   output logic      shift,
   output logic      set_done
);
   tx_phase_t phase_q, phase_d;

   assign load     = wr_req && (phase_q == PH_IDLE);
   assign shift    = tick && (phase_q == PH_DATA);
   assign set_done = shift && at_last;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE:  if (load) phase_d = PH_WAIT;
         PH_WAIT:  if (tick) phase_d = PH_START;
         PH_START: if (tick) phase_d = PH_DATA;
         PH_DATA:  if (set_done) phase_d = PH_IDLE;
         default:  phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end

   assign phase = phase_q;
endmodule

// File: rtl/ntx_done_flag.sv
module ntx_done_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/ninebit_frame_tx.sv
module ninebit_frame_tx
   import ninebit_tx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_bit9,
   input  logic              tx_clr,
   output logic              txd,
   output logic              tx_done
);
   localparam int SW = DATA_W + 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("ninebit_frame_tx: DATA_W must be at least 2");
   end

   tx_phase_t     phase;
   logic          load, shift, set_done, lsb, at_last, line_c;
   logic [SW-1:0] frame;

   ntx_sequencer u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (bit_tick),
      .wr_req   (wr_stb),
      .at_last  (at_last),
      .phase    (phase),
      .load     (load),
      .shift    (shift),
      .set_done (set_done)
   );

   ntx_shifter #(.W(SW)) u_shf (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val ({wr_bit9, wr_data}),
      .shift    (shift),
      .lsb      (lsb),
      .at_last  (at_last),
      .frame    (frame)
   );

   ntx_done_flag u_done (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (set_done),
      .clr   (tx_clr),
      .q     (tx_done)
   );

   always_comb begin
      unique case (phase)
         PH_START: line_c = 1'b0;
         PH_DATA:  line_c = lsb;
         default:  line_c = 1'b1;
      endcase
   end

   if (OUT_REG) begin : g_out_reg
      logic txd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) txd_q <= 1'b1;
         else        txd_q <= line_c;
      end
      assign txd = txd_q;
   end else begin : g_out_comb
      assign txd = line_c;
   end
endmodule

// File: rtl/ninebit_frame_tx_chk.sv
module ninebit_frame_tx_chk
   import ninebit_tx_pkg::*;
#(
   parameter int SW = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bit_tick,
   input logic          wr_stb,
   input logic          tx_clr,
   input logic          tx_done,
   input logic          line_c,
   input tx_phase_t     phase,
   input logic [SW-1:0] frame
);
   p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE || phase == PH_WAIT) |-> line_c);

   p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_START) |-> !line_c);

   p_wait_to_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT && bit_tick) |=> (phase == PH_START));

   p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && (phase == PH_WAIT || phase == PH_START)) |=> $stable(frame));

   p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done && !tx_clr) |=> tx_done);

   p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done && tx_clr && phase != PH_DATA) |=> !tx_done);

   p_done_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_done) |-> $past(bit_tick));
endmodule

bind ninebit_frame_tx ninebit_frame_tx_chk #(.SW(SW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bit_tick (bit_tick),
   .wr_stb   (wr_stb),
   .tx_clr   (tx_clr),
   .tx_done  (tx_done),
   .line_c   (line_c),
   .phase    (phase),
   .frame    (frame)
);

// File: tb/ninebit_frame_tx_tb.sv
`timescale 1ns/1ps
module ninebit_frame_tx_tb;
   localparam int DW = 8;
   localparam int LAST_K = DW + 3;   // tick count that ends a frame

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_tick;
   logic wr_stb = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic wr_bit9 = 1'b0;
   logic tx_clr = 1'b0;
   logic txd, tx_done;

   int checks = 0;
   int errors = 0;
   int tcnt = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   always @(negedge clk) tcnt <= (tcnt == 15) ? 0 : tcnt + 1;
   assign bit_tick = (tcnt == 15);

   ninebit_frame_tx #(.DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_stb(wr_stb),
      .wr_data(wr_data), .wr_bit9(wr_bit9), .tx_clr(tx_clr),
      .txd(txd), .tx_done(tx_done)
   );

   // ---------------- reference model ----------------
   int  m_k = -1;          // ticks since accepted write, -1 when idle
   bit  m_done = 1'b0;
   bit  m_busywr = 1'b0;
   bit  fq[$];

   always @(posedge clk) begin
      int k;
      bit set;
      if (!rst_n) begin
         m_k = -1; m_done = 1'b0; m_busywr = 1'b0;
      end else begin
         k = m_k; set = 1'b0;
         if (bit_tick && k >= 0) k = k + 1;
         if (k == LAST_K) begin k = -1; set = 1'b1; end
         if (wr_stb && m_k >= 0) m_busywr = 1'b1;
         if (wr_stb && m_k < 0) begin   // R2: accept only when idle
            fq = {};
            fq.push_back(1'b0);
            for (int i = 0; i < DW; i++) fq.push_back(wr_data[i]);
            fq.push_back(wr_bit9);
            k = 0;
            m_busywr = 1'b0;
         end
         if (set)         m_done = 1'b1;
         else if (tx_clr) m_done = 1'b0;
         m_k = k;
      end
   end

   function automatic bit exp_txd();
      if (m_k >= 1 && m_k <= DW + 2) return fq[m_k - 1];
      return 1'b1;
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         string tg;
         checks++;
         if (txd !== exp_txd()) begin
            errors++;
            tg = m_busywr ? "R6" : (m_k == 1) ? "R3" : (m_k >= 2) ? "R4" : "R8";
            $display("FAIL %s txd actual=%b expected=%b (k=%0d)", tg, txd, exp_txd(), m_k);
         end
         checks++;
         if (tx_done !== m_done) begin
            errors++;
            tg = tx_clr ? "R7" : "R5";
            $display("FAIL %s tx_done actual=%b expected=%b", tg, tx_done, m_done);
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic write(input logic [DW-1:0] d, input logic b9);
      @(negedge clk);
      wr_stb = 1'b1; wr_data = d; wr_bit9 = b9;
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic write_on_tick(input logic [DW-1:0] d, input logic b9);
      do @(posedge clk); while (tcnt != 14);
      write(d, b9);   // strobe lands in the tick cycle (R3)
   endtask

   task automatic wait_idle();
      do @(posedge clk); while (m_k >= 0);
      repeat (3) @(posedge clk);
   endtask

   task automatic clear_done();
      @(negedge clk); tx_clr = 1'b1;
      @(negedge clk); tx_clr = 1'b0;
   endtask

   task automatic wait_k(input int k);
      do @(posedge clk); while (m_k != k);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      checks++;   // R1 during reset
      if (txd !== 1'b1 || tx_done !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset txd=%b done=%b expected txd=1 done=0", txd, tx_done);
      end
      rst_n = 1'b1;
      repeat (20) @(negedge clk);

      write(8'h55, 1'b1);            // R2, R4, R5
      wait_idle();
      repeat (10) @(negedge clk);    // R7 hold without clear
      clear_done();

      write_on_tick(8'hA3, 1'b0);    // R3 tick coinciding with write
      wait_idle(); clear_done();

      write(8'h02, 1'b0);            // bit 1 only: early end trap
      wait_idle(); clear_done();

      write(8'h00, 1'b0);            // R6 busy writes in each phase
      write(8'hFF, 1'b1);            // during wait
      wait_k(1); write(8'hFF, 1'b1); // during start
      wait_k(5); write(8'hFF, 1'b1); // during data
      wait_idle(); clear_done();

      write(8'hFF, 1'b1);            // R7 clear held across the set
      wait_k(LAST_K - 1);
      @(negedge clk); tx_clr = 1'b1;
      wait_idle();
      @(negedge clk); tx_clr = 1'b0;

      write(8'h3C, 1'b1);            // R9 back to back, done left set
      wait_idle();
      write(8'hC6, 1'b0);
      wait_idle();
      write_on_tick(8'h81, 1'b1);
      wait_idle(); clear_done();
      repeat (5) @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule